// File: doc/BRIEF.md
# Burst Configuration Command Decoder

This block sits on the host write path of a flash device. It watches write cycles for the three-write command that programs the burst configuration register, and keeps that register. The register value comes from address bits 17 to 12 of the third write, not from the data bus. The register's fields are driven straight to the read path. They choose between asynchronous and synchronous burst reads, between continuous and fixed-length bursts, the burst length code and the count of wait states for the first access.

The host gives one strobe per write cycle, with the address and data of that cycle. A busy input says that a program, erase or sector lock/unlock operation is in progress. While busy is high, a command that is otherwise complete is refused. The register keeps its value until the next hardware reset, which brings back the default (asynchronous reads). Write cycles that belong to other commands pass through the decoder and leave the register untouched.

Top module: `bcfg_cmd_decoder`

## Requirements
- R1: After reset the register holds the default code 00h. The synchronous enable output is then 0, which selects asynchronous reads, and every other field output is 0.
- R2: A complete valid command loads wr_addr_i[17:12] into the register. The outputs show the new value on the clock edge that samples the third write.
- R3: The command has three writes, each compared on address bits 11:0. The first is data AAh at 555h, the second is data 55h at 2AAh and the third is data C0h at 555h. A wrong data or address value at any step stops the load.
- R4: A write that does not match the expected step returns the decoder to idle. A later third-cycle write on its own therefore loads nothing, and only a fresh full sequence loads.
- R5: If busy_i is high in the cycle that samples the third write, the register does not change. Busy during the first two writes has no effect.
- R6: Cycles with wr_en_i low are ignored, so idle cycles between the writes of a command are allowed. Address bits above bit 17 are ignored.
- R7: Once loaded, the register keeps its value through idle cycles, unrelated writes and failed sequences, until reset.
- R8: The field mapping of the 6-bit code is as follows. Bit 5 drives cfg_sync_o (1 = synchronous). Bit 4 drives cfg_cont_o (1 = continuous). Bits 3:2 drive cfg_len_o. Bits 1:0 drive cfg_wait_o.
- R9: With STRICT_HI set and DATA_W above 8, a command write matches only if data bits above bit 7 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | One-cycle strobe per host write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| busy_i | input | 1 | Program, erase or sector-lock activity in progress |
| cfg_sync_o | output | 1 | Synchronous burst read enable |
| cfg_cont_o | output | 1 | Continuous (1) or fixed-length (0) burst |
| cfg_len_o | output | 2 | Burst length code |
| cfg_wait_o | output | 2 | Initial-access wait-state count |

## Verification
The bench builds the block with a 20-bit address, a 16-bit data bus and STRICT_HI set. The wider address lets the bench drive high bits that must be ignored. The 16-bit data bus with strict matching lets it show that a nonzero upper data byte spoils an otherwise valid command write. Directed scenarios cover a corrupt value at each of the three steps, a break followed by a lone third write, and busy raised at different steps. They also check that the register keeps its value through idle gaps and foreign writes.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
   localparam int unsigned KEY_W    = 12;
   localparam int unsigned CODE_LSB = 12;
   localparam int unsigned CODE_W   = 6;
   localparam int unsigned N_STEPS  = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ONE  = 2'd1,
      ST_TWO  = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic       sync_en;
      logic       cont;
      logic [1:0] len;
      logic [1:0] waits;
   } bcfg_code_t;

   function automatic logic [KEY_W-1:0] step_addr(input int unsigned idx);
      case (idx)
         0:       return 12'h555;
         1:       return 12'h2AA;
         default: return 12'h555;
      endcase
   endfunction

   function automatic logic [7:0] step_data(input int unsigned idx);
      case (idx)
         0:       return 8'hAA;
         1:       return 8'h55;
         default: return 8'hC0;
      endcase
   endfunction
endpackage

// File: rtl/bcfg_step_match.sv
module bcfg_step_match #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned KEY_W     = 12,
   parameter bit          STRICT_HI = 1'b1,
   parameter logic [KEY_W-1:0] KEY_ADDR = '0,
   parameter logic [7:0]       KEY_DATA = '0
) (
   input  logic [KEY_W-1:0]  addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              hit_o
);
   logic lo_hit;
   logic hi_ok;

   if (DATA_W < 8) begin : g_chk_w
      initial $error("bcfg_step_match: DATA_W must be at least 8");
   end

   assign lo_hit = (addr_i == KEY_ADDR) && (data_i[7:0] == KEY_DATA);

   if (DATA_W > 8 && STRICT_HI) begin : g_strict
      assign hi_ok = (data_i[DATA_W-1:8] == '0);
   end else if (DATA_W > 8) begin : g_loose
      logic unused_hi;
      assign unused_hi = ^data_i[DATA_W-1:8];
      assign hi_ok = 1'b1;
   end else begin : g_narrow
      assign hi_ok = 1'b1;
   end

   assign hit_o = lo_hit && hi_ok;
endmodule

// File: rtl/bcfg_seq_fsm.sv
module bcfg_seq_fsm
   import bcfg_pkg::*;
#(
   parameter int unsigned STEPS = N_STEPS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [STEPS-1:0] hit_i,
   input  logic             busy_i,
   output logic             load_o
);
   seq_state_t st_q, st_d;

   if (STEPS != 3) begin : g_chk_steps
      initial $error("bcfg_seq_fsm: sequence is defined for three steps");
   end

   always_comb begin
      st_d = st_q;
      if (wr_en_i) begin
         unique case (st_q)
            ST_IDLE: st_d = hit_i[0] ? ST_ONE : ST_IDLE;
            ST_ONE:  st_d = hit_i[1] ? ST_TWO : ST_IDLE;
            ST_TWO:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign load_o = wr_en_i && (st_q == ST_TWO) && hit_i[2] && !busy_i;

   a_r4_break_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && st_q == ST_ONE && !hit_i[1]) |=> (st_q == ST_IDLE));

   a_r4_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != 2'd3);

   a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(st_q));

   a_r2_load_only_after_two: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> $past(wr_en_i) || $past(st_q) == ST_TWO);
endmodule

// File: rtl/bcfg_cfg_reg.sv
module bcfg_cfg_reg #(
   parameter int unsigned CODE_W = 6,
   parameter logic [CODE_W-1:0] DEFAULT_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= DEFAULT_CODE;
      else if (load_i) code_q <= code_i;
   end

   assign code_o = code_q;

   a_r7_hold_unless_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(code_q));
endmodule

// File: rtl/bcfg_cmd_decoder.sv
module bcfg_cmd_decoder
   import bcfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned DATA_W    = 16,
   parameter bit          STRICT_HI = 1'b1,
   parameter logic [CODE_W-1:0] DEFAULT_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              busy_i,
   output logic              cfg_sync_o,
   output logic              cfg_cont_o,
   output logic [1:0]        cfg_len_o,
   output logic [1:0]        cfg_wait_o
);
   localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

   logic [N_STEPS-1:0] hit;
   logic               load;
   logic [CODE_W-1:0]  code_q;
   bcfg_code_t         fields;

   if (ADDR_W < CODE_MSB + 1) begin : g_chk_addr
      initial $error("bcfg_cmd_decoder: ADDR_W too small for the code field");
   end
   if ($bits(bcfg_code_t) != CODE_W) begin : g_chk_code
      initial $error("bcfg_cmd_decoder: code layout does not match CODE_W");
   end

   if (ADDR_W > CODE_MSB + 1) begin : g_hi_addr
      logic unused_addr_hi;
      assign unused_addr_hi = ^wr_addr_i[ADDR_W-1:CODE_MSB+1];
   end

   for (genvar s = 0; s < N_STEPS; s++) begin : g_step
      bcfg_step_match #(
         .DATA_W   (DATA_W),
         .KEY_W    (KEY_W),
         .STRICT_HI(STRICT_HI),
         .KEY_ADDR (step_addr(s)),
         .KEY_DATA (step_data(s))
      ) i_match (
         .addr_i(wr_addr_i[KEY_W-1:0]),
         .data_i(wr_data_i),
         .hit_o (hit[s])
      );
   end

   bcfg_seq_fsm #(.STEPS(N_STEPS)) i_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr_en_i),
      .hit_i  (hit),
      .busy_i (busy_i),
      .load_o (load)
   );

   bcfg_cfg_reg #(.CODE_W(CODE_W), .DEFAULT_CODE(DEFAULT_CODE)) i_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .code_i(wr_addr_i[CODE_MSB:CODE_LSB]),
      .code_o(code_q)
   );

   assign fields     = bcfg_code_t'(code_q);
   assign cfg_sync_o = fields.sync_en;
   assign cfg_cont_o = fields.cont;
   assign cfg_len_o  = fields.len;
   assign cfg_wait_o = fields.waits;

   a_r5_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(code_q));

   a_r7_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> $past(wr_en_i));

   a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> code_q == $past(wr_addr_i[CODE_MSB:CODE_LSB]));
endmodule

// File: tb/test_bcfg_cmd_decoder.sv
module test_bcfg_cmd_decoder;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [19:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy = 1'b0;
   logic        sync_o, cont_o;
   logic [1:0]  len_o, wait_o;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcfg_cmd_decoder #(.ADDR_W(20), .DATA_W(16), .STRICT_HI(1'b1)) i_bcfg_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .busy_i(busy), .cfg_sync_o(sync_o),
      .cfg_cont_o(cont_o), .cfg_len_o(len_o), .cfg_wait_o(wait_o)
   );

   function automatic logic [5:0] cfg_now();
      return {sync_o, cont_o, len_o, wait_o};
   endfunction

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h, expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [19:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic step3(input logic [5:0] code, input logic [1:0] hi);
      bus_wr({hi, code, 12'h555}, 16'h00C0);
   endtask

   task automatic full_cmd(input logic [5:0] code);
      bus_wr(20'h00555, 16'h00AA);
      bus_wr(20'h002AA, 16'h0055);
      step3(code, 2'b00);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 reset default", cfg_now(), 6'h00);
      chk("R1 async after reset", {5'b0, sync_o}, 6'h00);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_basic_fields();
      full_cmd(6'h2D);
      chk("R2 load code", cfg_now(), 6'h2D);
      chk("R8 sync bit5", {5'b0, sync_o}, 6'h01);
      chk("R8 cont bit4", {5'b0, cont_o}, 6'h00);
      chk("R8 len bits3:2", {4'b0, len_o}, 6'h03);
      chk("R8 wait bits1:0", {4'b0, wait_o}, 6'h01);
      for (int k = 0; k < 4; k++) begin
         logic [5:0] c;
         c = 6'((k * 23 + 18) & 63);
         full_cmd(c);
         chk("R2 code sweep", cfg_now(), c);
      end
   endtask

   task automatic t_bad_steps();
      full_cmd(6'h11);
      bus_wr(20'h00555, 16'h00AB); bus_wr(20'h002AA, 16'h0055); step3(6'h22, 2'b00);
      chk("R3 bad data step1", cfg_now(), 6'h11);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h002AB, 16'h0055); step3(6'h22, 2'b00);
      chk("R3 bad addr step2", cfg_now(), 6'h11);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h002AA, 16'h0055);
      bus_wr({6'h22, 12'h555}, 16'h00C1);
      chk("R3 bad data step3", cfg_now(), 6'h11);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h002AA, 16'h0055);
      bus_wr({2'b00, 6'h22, 12'h556}, 16'h00C0);
      chk("R3 bad addr step3", cfg_now(), 6'h11);
   endtask

   task automatic t_break();
      full_cmd(6'h05);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h00123, 16'h0090); step3(6'h3A, 2'b00);
      chk("R4 lone third after break", cfg_now(), 6'h05);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h00555, 16'h00AA);
      bus_wr(20'h002AA, 16'h0055); step3(6'h3A, 2'b00);
      chk("R4 repeated first step breaks", cfg_now(), 6'h05);
      full_cmd(6'h3A);
      chk("R4 fresh sequence loads", cfg_now(), 6'h3A);
   endtask

   task automatic t_busy();
      full_cmd(6'h09);
      busy = 1'b1;
      full_cmd(6'h36);
      busy = 1'b0;
      chk("R5 busy whole command", cfg_now(), 6'h09);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h002AA, 16'h0055);
      busy = 1'b1; step3(6'h36, 2'b00); busy = 1'b0;
      chk("R5 busy on third write", cfg_now(), 6'h09);
      busy = 1'b1;
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h002AA, 16'h0055);
      busy = 1'b0; step3(6'h36, 2'b00);
      chk("R5 busy early only", cfg_now(), 6'h36);
   endtask

   task automatic t_gaps_hi();
      bus_wr(20'hC0555, 16'h00AA);
      repeat (3) @(negedge clk);
      bus_wr(20'h402AA, 16'h0055);
      repeat (5) @(negedge clk);
      step3(6'h1B, 2'b11);
      chk("R6 gaps and high address bits", cfg_now(), 6'h1B);
   endtask

   task automatic t_hi_byte();
      bus_wr(20'h00555, 16'h01AA); bus_wr(20'h002AA, 16'h0055); step3(6'h24, 2'b00);
      chk("R9 nonzero upper byte step1", cfg_now(), 6'h1B);
      bus_wr(20'h00555, 16'h00AA); bus_wr(20'h002AA, 16'h0055);
      bus_wr({6'h24, 12'h555}, 16'h80C0);
      chk("R9 nonzero upper byte step3", cfg_now(), 6'h1B);
   endtask

   task automatic t_persist();
      repeat (20) @(negedge clk);
      for (int k = 0; k < 6; k++) bus_wr(20'((k * 4099) & 20'hFFFFF), 16'((k * 97) & 16'hFFFF));
      chk("R7 held after foreign writes", cfg_now(), 6'h1B);
      t_reset();
      chk("R1 reset clears loaded value", cfg_now(), 6'h00);
   endtask

   initial begin
      t_reset();
      t_basic_fields();
      t_bad_steps();
      t_break();
      t_busy();
      t_gaps_hi();
      t_hi_byte();
      t_persist();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule